// File: doc/BRIEF.md
# Memory Error Capture Register Unit

This unit sits next to a 64-bit ECC-protected memory datapath. The ECC decode logic outside the unit reports each read with two strobes: one for a corrected single-bit error and one for an uncorrectable multi-bit error. For each read it also supplies the read data, the received check bits and the read address. The unit keeps sticky detect flags. It snapshots the failing read into capture registers and holds that snapshot until software acknowledges it. Single-bit errors are counted against a programmable threshold, so corrected-error interrupts can be rate limited. The unit drives one level interrupt.

Software can stop either error class from being detected. Software can also enable injection masks, which flip chosen data and check bits on the write path to exercise the ECC logic. Software accesses all registers through a plain 32-bit word-addressed bus. A write takes effect on the clock edge. A read returns data combinationally.

Top module: `memerr_capture_unit`

## Requirements
- R1: The detect register at word offset 0x0 holds the single-bit flag in bit 0 and the multi-bit flag in bit 1. An accepted multi-bit event sets bit 1 on the next clock edge. Both flags are 0 after reset.
- R2: Writing offset 0x0 clears each flag whose write-data bit is 1 and leaves the flags whose bit is 0 unchanged. If an event sets a flag in the same cycle as a write clears it, the set wins.
- R3: Each accepted event that arrives while both detect flags are 0 loads the capture registers: data high word (offset 0x4), data low word (0x5), check bits (0x6) and address (0x7). While any flag is set, the capture registers keep their values.
- R4: When `narrow_mode` is 0, the captured check bits keep only bits 7:0 of `rd_ecc`. When `narrow_mode` is 1, they keep bits 15:0.
- R5: The single-bit management register at offset 0x3 holds the threshold in bits 23:16 and a read-only count in bits 7:0. It reads 0x00010000 after reset. An accepted single-bit event adds one to the count. When the count reaches the threshold, the single-bit flag is set and the count returns to 0. A threshold of 0 behaves like 1. A write to offset 0x3 clears the count, and a single-bit event in that same cycle is not counted.
- R6: The interrupt enable register at offset 0x2 has bit 0 for single-bit and bit 1 for multi-bit errors, and resets to 0. `irq` is high exactly while some set detect flag has its enable bit set.
- R7: The disable register at offset 0x1 has bit 0 for single-bit and bit 1 for multi-bit errors. While a class is disabled, events of that class do not set flags, do not change the count and do not load the capture registers.
- R8: The injection registers are readable and writable: data-high mask at 0x8, data-low mask at 0x9, and control at 0xA. In the control register, bits 7:0 are the check-bit mask and bit 8 is the enable. The unused control bits read as 0.
- R9: While the injection enable is 1, `wr_data_out` equals `wr_data_in` XOR {high mask, low mask} and `wr_ecc_out` equals `wr_ecc_in` XOR the check-bit mask. While the enable is 0, both outputs equal their inputs.
- R10: Offsets 0xB through 0xF read as 0. Writes to the capture offsets 0x4 to 0x7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| narrow_mode | input | 1 | 1 = 32-bit bus mode (keep 16 check bits) |
| sbe_event | input | 1 | Corrected single-bit error on this read |
| mbe_event | input | 1 | Uncorrectable multi-bit error on this read |
| rd_data | input | 64 | Read data, high word in bits 63:32 |
| rd_ecc | input | 16 | Received check bits |
| rd_addr | input | 32 | Read address |
| wr_data_in | input | 64 | Write-path data before injection |
| wr_ecc_in | input | 8 | Write-path check bits before injection |
| wr_data_out | output | 64 | Write-path data after injection |
| wr_ecc_out | output | 8 | Write-path check bits after injection |
| irq | output | 1 | Level error interrupt |

## Verification
The properties assume the following about the inputs:
- The event strobes, read data and address are synchronous to `clk` and stay stable across the sampling edge.
- `narrow_mode` changes only while no event is being captured.

The stimulus changes every input on the falling edge and raises each strobe for exactly one cycle. It holds `narrow_mode` steady around its events and returns it to 0 afterwards. The stimulus also drives a write and an event in the same cycle on purpose, so the set-wins rule is exercised inside these limits.

// File: rtl/memerr_pkg.sv
// memerr_pkg: register offsets and shared widths for the memory error
// capture unit. Assumes a word-addressed 4-bit register space.
package memerr_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFF_DETECT  = 4'h0;
    localparam logic [REG_AW-1:0] OFF_DISABLE = 4'h1;
    localparam logic [REG_AW-1:0] OFF_INTEN   = 4'h2;
    localparam logic [REG_AW-1:0] OFF_SBEMGMT = 4'h3;
    localparam logic [REG_AW-1:0] OFF_CAP_HI  = 4'h4;
    localparam logic [REG_AW-1:0] OFF_CAP_LO  = 4'h5;
    localparam logic [REG_AW-1:0] OFF_CAP_ECC = 4'h6;
    localparam logic [REG_AW-1:0] OFF_CAP_ADR = 4'h7;
    localparam logic [REG_AW-1:0] OFF_INJ_HI  = 4'h8;
    localparam logic [REG_AW-1:0] OFF_INJ_LO  = 4'h9;
    localparam logic [REG_AW-1:0] OFF_INJ_CTL = 4'hA;

    // Bit index of each error class inside the flag-style registers.
    localparam int CLS_SBE = 0;
    localparam int CLS_MBE = 1;
    localparam int NUM_CLS = 2;

    // Threshold field position in the single-bit management register.
    localparam int THR_LSB = 16;

    typedef logic [NUM_CLS-1:0] cls_vec_t;
endpackage

// File: rtl/memerr_sbe_counter.sv
// memerr_sbe_counter: counts accepted single-bit events and reports when the
// programmed threshold is reached. A zero threshold is treated as one.
// Assumes clr and hit come from the same clock domain.
module memerr_sbe_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             reach
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   inc;
    logic [CNT_W-1:0] eff_thr;

    // Effective threshold and threshold-reach detection for this cycle.
    always_comb begin
        eff_thr = (thr == '0) ? ONE : thr;
        inc     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        reach   = hit && !clr && (inc >= {1'b0, eff_thr});
    end

    // Count register: cleared on write or on reaching threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= reach ? '0 : inc[CNT_W-1:0];
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/memerr_capture.sv
// memerr_capture: holds the snapshot of one failing read. Loads when load is
// high; the check-bit width kept depends on narrow mode.
// Assumes load is already gated by the detect-flag state.
module memerr_capture #(
    parameter int HALF_W = 32,
    parameter int ECC_W  = 16,
    parameter int CHK_W  = 8,
    parameter int EA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              narrow,
    input  logic [2*HALF_W-1:0] data,
    input  logic [ECC_W-1:0]  ecc,
    input  logic [EA_W-1:0]   addr,
    output logic [HALF_W-1:0] cap_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [ECC_W-1:0]  cap_ecc,
    output logic [EA_W-1:0]   cap_addr
);
    localparam logic [ECC_W-1:0] WIDE_MASK = ECC_W'((1 << CHK_W) - 1);

    logic [ECC_W-1:0] ecc_kept;

    // Mask the check bits that are meaningful for the bus mode.
    always_comb begin
        ecc_kept = narrow ? ecc : (ecc & WIDE_MASK);
    end

    // Snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hi   <= '0;
            cap_lo   <= '0;
            cap_ecc  <= '0;
            cap_addr <= '0;
        end else if (load) begin
            cap_hi   <= data[2*HALF_W-1:HALF_W];
            cap_lo   <= data[HALF_W-1:0];
            cap_ecc  <= ecc_kept;
            cap_addr <= addr;
        end
    end
endmodule

// File: rtl/memerr_inject.sv
// memerr_inject: holds the write-path injection masks and applies them to
// outgoing data and check bits while the enable bit is set.
// Assumes the data word is two bus-width halves, high half first.
module memerr_inject #(
    parameter int HALF_W = 32,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic              we_ctl,
    input  logic [HALF_W-1:0] wdata,
    input  logic [2*HALF_W-1:0] din,
    input  logic [CHK_W-1:0]  ein,
    output logic [2*HALF_W-1:0] dout,
    output logic [CHK_W-1:0]  eout,
    output logic [HALF_W-1:0] mask_hi,
    output logic [HALF_W-1:0] mask_lo,
    output logic [CHK_W:0]    ctl
);
    localparam int NUM_HALF = 2;

    logic [HALF_W-1:0] mask_arr [NUM_HALF];
    logic              inj_on;

    // Mask and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi <= '0;
            mask_lo <= '0;
            ctl     <= '0;
        end else begin
            if (we_hi)  mask_hi <= wdata;
            if (we_lo)  mask_lo <= wdata;
            if (we_ctl) ctl     <= wdata[CHK_W:0];
        end
    end

    assign inj_on      = ctl[CHK_W];
    assign mask_arr[0] = mask_lo;
    assign mask_arr[1] = mask_hi;

    // One XOR lane per data half.
    for (genvar g = 0; g < NUM_HALF; g++) begin : g_lane
        assign dout[g*HALF_W +: HALF_W] =
            din[g*HALF_W +: HALF_W] ^ (inj_on ? mask_arr[g] : '0);
    end

    // Check-bit flip.
    always_comb begin
        eout = ein ^ (inj_on ? ctl[CHK_W-1:0] : '0);
    end
endmodule

// File: rtl/memerr_capture_unit.sv
// memerr_capture_unit: top of the memory error capture register unit.
// Decodes the register bus, keeps detect/disable/enable/threshold state,
// and ties together the counter, capture and injection sub-blocks.
// Assumes event strobes are one-cycle, synchronous to clk.
module memerr_capture_unit
    import memerr_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int ECC_W = 16,
    parameter int CHK_W = 8,
    parameter int EA_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 narrow_mode,
    input  logic                 sbe_event,
    input  logic                 mbe_event,
    input  logic [2*BUS_W-1:0]   rd_data,
    input  logic [ECC_W-1:0]     rd_ecc,
    input  logic [EA_W-1:0]      rd_addr,
    input  logic [2*BUS_W-1:0]   wr_data_in,
    input  logic [CHK_W-1:0]     wr_ecc_in,
    output logic [2*BUS_W-1:0]   wr_data_out,
    output logic [CHK_W-1:0]     wr_ecc_out,
    output logic                 irq
);
    localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(1);

    cls_vec_t         det_q, dis_q, ien_q;
    cls_vec_t         det_set, det_clr;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] sbe_cnt;
    logic             sbe_reach;
    logic             sbe_hit, mbe_hit, cap_load;
    logic             wr_det, wr_dis, wr_ien, wr_mgmt;
    logic [BUS_W-1:0] cap_hi, cap_lo, cap_addr_w;
    logic [ECC_W-1:0] cap_ecc;
    logic [BUS_W-1:0] inj_hi, inj_lo;
    logic [CHK_W:0]   inj_ctl;
    logic [EA_W-1:0]  cap_addr;

    // Write strobe decode.
    always_comb begin
        wr_det  = bus_wr_en && (bus_addr == OFF_DETECT);
        wr_dis  = bus_wr_en && (bus_addr == OFF_DISABLE);
        wr_ien  = bus_wr_en && (bus_addr == OFF_INTEN);
        wr_mgmt = bus_wr_en && (bus_addr == OFF_SBEMGMT);
    end

    // Event qualification against the disable mask.
    always_comb begin
        sbe_hit  = sbe_event && !dis_q[CLS_SBE];
        mbe_hit  = mbe_event && !dis_q[CLS_MBE];
        cap_load = (sbe_hit || mbe_hit) && (det_q == '0);
    end

    // Flag set and write-one-to-clear vectors.
    always_comb begin
        det_set          = '0;
        det_set[CLS_SBE] = sbe_reach;
        det_set[CLS_MBE] = mbe_hit;
        det_clr          = wr_det ? bus_wdata[NUM_CLS-1:0] : '0;
    end

    // Detect flags: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= (det_q & ~det_clr) | det_set;
    end

    // Disable, interrupt enable and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= '0;
            ien_q <= '0;
            thr_q <= THR_RESET;
        end else begin
            if (wr_dis)  dis_q <= bus_wdata[NUM_CLS-1:0];
            if (wr_ien)  ien_q <= bus_wdata[NUM_CLS-1:0];
            if (wr_mgmt) thr_q <= bus_wdata[THR_LSB +: CNT_W];
        end
    end

    memerr_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_mgmt),
        .hit   (sbe_hit),
        .thr   (thr_q),
        .cnt   (sbe_cnt),
        .reach (sbe_reach)
    );

    memerr_capture #(
        .HALF_W(BUS_W), .ECC_W(ECC_W), .CHK_W(CHK_W), .EA_W(EA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap_load),
        .narrow   (narrow_mode),
        .data     (rd_data),
        .ecc      (rd_ecc),
        .addr     (rd_addr),
        .cap_hi   (cap_hi),
        .cap_lo   (cap_lo),
        .cap_ecc  (cap_ecc),
        .cap_addr (cap_addr)
    );

    memerr_inject #(.HALF_W(BUS_W), .CHK_W(CHK_W)) u_inj (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_hi   (bus_wr_en && (bus_addr == OFF_INJ_HI)),
        .we_lo   (bus_wr_en && (bus_addr == OFF_INJ_LO)),
        .we_ctl  (bus_wr_en && (bus_addr == OFF_INJ_CTL)),
        .wdata   (bus_wdata),
        .din     (wr_data_in),
        .ein     (wr_ecc_in),
        .dout    (wr_data_out),
        .eout    (wr_ecc_out),
        .mask_hi (inj_hi),
        .mask_lo (inj_lo),
        .ctl     (inj_ctl)
    );

    assign cap_addr_w = BUS_W'(cap_addr);

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_DETECT:  bus_rdata[NUM_CLS-1:0] = det_q;
            OFF_DISABLE: bus_rdata[NUM_CLS-1:0] = dis_q;
            OFF_INTEN:   bus_rdata[NUM_CLS-1:0] = ien_q;
            OFF_SBEMGMT: begin
                bus_rdata[THR_LSB +: CNT_W] = thr_q;
                bus_rdata[CNT_W-1:0]        = sbe_cnt;
            end
            OFF_CAP_HI:  bus_rdata = cap_hi;
            OFF_CAP_LO:  bus_rdata = cap_lo;
            OFF_CAP_ECC: bus_rdata[ECC_W-1:0] = cap_ecc;
            OFF_CAP_ADR: bus_rdata = cap_addr_w;
            OFF_INJ_HI:  bus_rdata = inj_hi;
            OFF_INJ_LO:  bus_rdata = inj_lo;
            OFF_INJ_CTL: bus_rdata[CHK_W:0] = inj_ctl;
            default:     bus_rdata = '0;
        endcase
    end

    // Level interrupt from enabled, set flags.
    always_comb begin
        irq = |(det_q & ien_q);
    end
endmodule

// File: rtl/memerr_capture_unit_chk.sv
// memerr_capture_unit_chk: temporal properties of the capture unit, attached
// by bind. Assumes strobes are synchronous to clk.
module memerr_capture_unit_chk #(
    parameter int BUS_W = 32,
    parameter int EA_W  = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sbe_event,
    input logic             mbe_event,
    input logic             bus_wr_en,
    input logic [3:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [1:0]       det_q,
    input logic [1:0]       dis_q,
    input logic [CNT_W-1:0] thr_q,
    input logic [CNT_W-1:0] sbe_cnt,
    input logic [BUS_W-1:0] cap_hi,
    input logic [EA_W-1:0]  cap_addr,
    input logic             irq
);
    // R1
    mbe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_event && !dis_q[1]) |=> det_q[1]);

    // R2
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 4'h0 && bus_wdata[0] && !sbe_event) |=> !det_q[0]);

    // R3
    capture_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q != 2'b00) |=> ($stable(cap_addr) && $stable(cap_hi)));

    // R5
    count_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sbe_cnt < ((thr_q == '0) ? CNT_W'(1) : thr_q));

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (det_q != 2'b00));

    // R7
    disabled_mbe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q[1] && !det_q[1]) |=> !det_q[1]);
endmodule

bind memerr_capture_unit memerr_capture_unit_chk #(
    .BUS_W(BUS_W), .EA_W(EA_W), .CNT_W(CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sbe_event (sbe_event),
    .mbe_event (mbe_event),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .det_q     (det_q),
    .dis_q     (dis_q),
    .thr_q     (thr_q),
    .sbe_cnt   (sbe_cnt),
    .cap_hi    (cap_hi),
    .cap_addr  (cap_addr),
    .irq       (irq)
);

// File: tb/memerr_capture_unit_tb.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks with hand-computed expectations.
module memerr_capture_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        narrow_mode = 1'b0;
    logic        sbe_event = 1'b0, mbe_event = 1'b0;
    logic [63:0] rd_data = '0;
    logic [15:0] rd_ecc = '0;
    logic [31:0] rd_addr = '0;
    logic [63:0] wr_data_in = 64'h0F0F_0F0F_F0F0_F0F0;
    logic [7:0]  wr_ecc_in = 8'h3C;
    logic [63:0] wr_data_out;
    logic [7:0]  wr_ecc_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    memerr_capture_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .narrow_mode(narrow_mode),
        .sbe_event(sbe_event), .mbe_event(mbe_event), .rd_data(rd_data),
        .rd_ecc(rd_ecc), .rd_addr(rd_addr), .wr_data_in(wr_data_in),
        .wr_ecc_in(wr_ecc_in), .wr_data_out(wr_data_out),
        .wr_ecc_out(wr_ecc_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    logic [1:0]  m_det, m_dis, m_ien;
    int          m_thr, m_cnt;
    logic [31:0] m_hi, m_lo, m_adr, m_ihi, m_ilo;
    logic [15:0] m_ecc;
    logic [8:0]  m_ictl;

    always @(posedge clk) begin
        logic [1:0] set_v, clr_v;
        logic sa, ma;
        int nc, eff;
        if (!rst_n) begin
            m_det = 0; m_dis = 0; m_ien = 0; m_thr = 1; m_cnt = 0;
            m_hi = 0; m_lo = 0; m_adr = 0; m_ecc = 0;
            m_ihi = 0; m_ilo = 0; m_ictl = 0;
        end else begin
            sa = sbe_event && !m_dis[0];
            ma = mbe_event && !m_dis[1];
            set_v = 0; clr_v = 0; nc = m_cnt;
            eff = (m_thr == 0) ? 1 : m_thr;
            if (bus_wr_en && bus_addr == 3) nc = 0;
            else if (sa) begin
                if (m_cnt + 1 >= eff) begin set_v[0] = 1; nc = 0; end
                else nc = m_cnt + 1;
            end
            if (ma) set_v[1] = 1;
            if ((sa || ma) && m_det == 0) begin
                m_hi = rd_data[63:32]; m_lo = rd_data[31:0]; m_adr = rd_addr;
                m_ecc = narrow_mode ? rd_ecc : {8'h00, rd_ecc[7:0]};
            end
            if (bus_wr_en) begin
                case (bus_addr)
                    4'h0: clr_v = bus_wdata[1:0];
                    4'h1: m_dis = bus_wdata[1:0];
                    4'h2: m_ien = bus_wdata[1:0];
                    4'h3: m_thr = int'(bus_wdata[23:16]);
                    4'h8: m_ihi = bus_wdata;
                    4'h9: m_ilo = bus_wdata;
                    4'hA: m_ictl = bus_wdata[8:0];
                    default: ;
                endcase
            end
            m_det = (m_det & ~clr_v) | set_v;
            m_cnt = nc;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return {30'b0, m_det};
            4'h1: return {30'b0, m_dis};
            4'h2: return {30'b0, m_ien};
            4'h3: return (32'(m_thr) << 16) | 32'(m_cnt);
            4'h4: return m_hi;
            4'h5: return m_lo;
            4'h6: return {16'h0, m_ecc};
            4'h7: return m_adr;
            4'h8: return m_ihi;
            4'h9: return m_ilo;
            4'hA: return {23'b0, m_ictl};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h0: return "R1";
            4'h1: return "R7";
            4'h2: return "R6";
            4'h3: return "R5";
            4'h4, 4'h5, 4'h7: return "R3";
            4'h6: return "R4";
            4'h8, 4'h9, 4'hA: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model, after the edge settles.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [63:0] xd;
            logic [7:0]  xe;
            xd = wr_data_in ^ (m_ictl[8] ? {m_ihi, m_ilo} : 64'h0);
            xe = wr_ecc_in ^ (m_ictl[8] ? m_ictl[7:0] : 8'h0);
            check(tag_of(bus_addr), 64'(bus_rdata), 64'(exp_rd(bus_addr)));
            check("R6", 64'(irq), 64'(|(m_det & m_ien)));
            check("R9", wr_data_out, xd);
            check("R9", 64'(wr_ecc_out), 64'(xe));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 0; bus_addr = 0;
    endtask

    task automatic ev(input logic s, input logic m, input logic [63:0] d,
                      input logic [15:0] e, input logic [31:0] a);
        @(negedge clk);
        sbe_event = s; mbe_event = m; rd_data = d; rd_ecc = e; rd_addr = a;
        @(negedge clk);
        sbe_event = 0; mbe_event = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #2;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Reset state
        rd_chk("R1", 4'h0, 32'h0);
        rd_chk("R5", 4'h3, 32'h0001_0000);
        check("R6", 64'(irq), 64'h0);
        // R1 R3 R4 R6: multi-bit event captured
        wr(4'h2, 32'h3);
        ev(0, 1, 64'hDEADBEEF_01234567, 16'h01A5, 32'h1000);
        rd_chk("R1", 4'h0, 32'h2);
        rd_chk("R3", 4'h4, 32'hDEADBEEF);
        rd_chk("R3", 4'h5, 32'h01234567);
        rd_chk("R4", 4'h6, 32'h0000_00A5);
        rd_chk("R3", 4'h7, 32'h1000);
        check("R6", 64'(irq), 64'h1);
        // R3: later event does not overwrite
        ev(0, 1, 64'h11111111_22222222, 16'h0033, 32'h2000);
        rd_chk("R3", 4'h7, 32'h1000);
        // R2: partial then full clear
        wr(4'h0, 32'h1);
        rd_chk("R2", 4'h0, 32'h2);
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk("R2", 4'h0, 32'h0);
        check("R6", 64'(irq), 64'h0);
        // R5: threshold 3
        wr(4'h3, 32'h0003_0000);
        ev(1, 0, 64'hA, 16'h1, 32'h3000);
        ev(1, 0, 64'hB, 16'h2, 32'h3004);
        rd_chk("R5", 4'h0, 32'h0);
        rd_chk("R5", 4'h3, 32'h0003_0002);
        ev(1, 0, 64'hC, 16'h3, 32'h3008);
        rd_chk("R5", 4'h0, 32'h1);
        rd_chk("R5", 4'h3, 32'h0003_0000);
        rd_chk("R3", 4'h7, 32'h3008);
        wr(4'h0, 32'h3);
        // R4: narrow mode keeps 16 bits
        @(negedge clk); narrow_mode = 1;
        ev(0, 1, 64'h5, 16'h01A5, 32'h4000);
        @(negedge clk); narrow_mode = 0;
        rd_chk("R4", 4'h6, 32'h0000_01A5);
        wr(4'h0, 32'h3);
        // R7: disabled classes ignored
        wr(4'h1, 32'h3);
        ev(1, 1, 64'h7, 16'h7, 32'h5000);
        rd_chk("R7", 4'h0, 32'h0);
        rd_chk("R7", 4'h7, 32'h4000);
        rd_chk("R7", 4'h3, 32'h0003_0000);
        wr(4'h1, 32'h0);
        // R5: zero threshold acts as one
        wr(4'h3, 32'h0);
        ev(1, 0, 64'h9, 16'h9, 32'h6000);
        rd_chk("R5", 4'h0, 32'h1);
        // R2: set wins over same-cycle clear
        @(negedge clk);
        bus_wr_en = 1; bus_addr = 4'h0; bus_wdata = 32'h1;
        sbe_event = 1; rd_addr = 32'h7000;
        @(negedge clk);
        bus_wr_en = 0; sbe_event = 0;
        rd_chk("R2", 4'h0, 32'h1);
        rd_chk("R3", 4'h7, 32'h6000);
        wr(4'h0, 32'h1);
        // R8 R9: injection
        wr(4'h8, 32'hFFFF_0000);
        wr(4'h9, 32'h0000_00FF);
        wr(4'hA, 32'h0000_00AA);
        check("R9", wr_data_out, 64'h0F0F_0F0F_F0F0_F0F0);
        rd_chk("R8", 4'h8, 32'hFFFF_0000);
        rd_chk("R8", 4'h9, 32'h0000_00FF);
        wr(4'hA, 32'hFFFF_FFFF);
        rd_chk("R8", 4'hA, 32'h0000_01FF);
        check("R9", wr_data_out, 64'hF0F0_0F0F_F0F0_F00F);
        check("R9", 64'(wr_ecc_out), 64'hC3);
        // R10: unmapped reads and read-only capture
        rd_chk("R10", 4'hF, 32'h0);
        rd_chk("R10", 4'hB, 32'h0);
        wr(4'h7, 32'h1234_5678);
        rd_chk("R10", 4'h7, 32'h6000);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule